// File: doc/BRIEF.md
# VLAN Violation Capture and Interrupt

This block watches the result of a VLAN table lookup and keeps one record of the first policy violation it sees. Each lookup gives an ingress source port, a VLAN ID, a hit flag and a member flag. If the VLAN ID has no valid table entry, the violation is a miss. If the entry exists but the source port is not a member of it, the violation is a member violation. The block latches the VLAN ID, the source port and the cause. It then holds a level interrupt asserted until the host collects the record.

The host collects the record with a one-cycle get-and-clear pulse. That pulse copies the pending record into readback registers and empties the pending slot. While a record is pending, newer violations are dropped. A sticky overflow bit shows that at least one was lost.

The readback word uses fixed bit positions:
- Bits [3:0] hold the source port.
- Bit 5 is the miss flag.
- Bit 6 is the member flag.
- Bit 7 is the overflow flag.
- All other bits read zero.

Top module: `vlan_viol_capture`

## Requirements
- R1: After reset, irq_o is 0, rd_word_o is 0 and rd_vid_o is 0.
- R2: A lookup with lkp_valid_i=1 and lkp_hit_i=0 is a miss violation, whatever lkp_member_i is. Its later readback has bit 5 set, bit 6 clear, the port in bits [3:0] and the VLAN ID on rd_vid_o.
- R3: A lookup with lkp_valid_i=1, lkp_hit_i=1 and lkp_member_i=0 is a member violation. Its readback has bit 6 set and bit 5 clear.
- R4: A lookup with lkp_hit_i=1 and lkp_member_i=1, or any lookup with lkp_valid_i=0, records nothing. irq_o stays 0, and a following get-and-clear reads all zeros.
- R5: irq_o is 1 from the cycle after a captured violation until a get-and-clear takes that record.
- R6: A get-and-clear pulse loads rd_word_o and rd_vid_o at the same clock edge. If no new violation is captured at that edge, irq_o is 0 in the next cycle.
- R7: While a record is pending, later violations do not change it.
- R8: A violation dropped under R7 sets bit 7 of the next readback word. The get-and-clear that reports it also clears it.
- R9: A get-and-clear with nothing pending loads a zero word and a zero VLAN ID.
- R10: If a violation and a get-and-clear arrive in the same cycle, the old record is read out. The new violation becomes pending without setting overflow.
- R11: Readback bits 4 and 15:8 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup result valid this cycle |
| lkp_port_i | input | PORT_W | Ingress source port of the lookup |
| lkp_vid_i | input | VID_W | VLAN ID of the lookup |
| lkp_hit_i | input | 1 | VLAN ID has a valid table entry |
| lkp_member_i | input | 1 | Source port is a member of the VLAN |
| clr_i | input | 1 | Get-and-clear command, one cycle |
| rd_word_o | output | 16 | Readback word: port, miss, member, overflow |
| rd_vid_o | output | VID_W | Readback VLAN ID |
| irq_o | output | 1 | Level interrupt, violation pending |

## Verification
A corrupted pending record does not show until the next get-and-clear. It then appears as a wrong port, VLAN ID or cause bit in the readback word, one cycle after the pulse. A stuck or lost pending bit shows on irq_o within one cycle of the lookup or of the clear. A wrong overflow state shows only in bit 7 of the next readback. For that reason the bench stacks violations and collides them with clears, and then reads the record out twice.

// File: rtl/vvc_pkg.sv
package vvc_pkg;
  localparam int unsigned RD_W     = 16;
  localparam int unsigned PORT_MAX = 4;
  localparam int unsigned MISS_BIT = 5;
  localparam int unsigned MEMB_BIT = 6;
  localparam int unsigned OVF_BIT  = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_MISS   = 2'd1,
    CAUSE_MEMBER = 2'd2
  } cause_e;
endpackage

// File: rtl/vvc_classify.sv
module vvc_classify
  import vvc_pkg::*;
(
  input  logic   valid_i,
  input  logic   hit_i,
  input  logic   member_i,
  output cause_e cause_o
);
  always_comb begin
    if (!valid_i)       cause_o = CAUSE_NONE;
    else if (!hit_i)    cause_o = CAUSE_MISS;   // miss wins over member
    else if (!member_i) cause_o = CAUSE_MEMBER;
    else                cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/vvc_capture.sv
module vvc_capture
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cause_e            cause_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              clr_i,
  output logic              pend_o,
  output cause_e            cause_o,
  output logic [VID_W-1:0]  vid_o,
  output logic [PORT_W-1:0] port_o,
  output logic              ovf_o
);
  logic              pend_q, ovf_q;
  cause_e            cause_q;
  logic [VID_W-1:0]  vid_q;
  logic [PORT_W-1:0] port_q;
  logic              viol, take;

  assign viol = (cause_i != CAUSE_NONE);
  // slot is free if empty or being emptied this cycle
  assign take = viol && (!pend_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
      vid_q   <= '0;
      port_q  <= '0;
    end else if (take) begin
      pend_q  <= 1'b1;
      cause_q <= cause_i;
      vid_q   <= vid_i;
      port_q  <= port_i;
    end else if (clr_i) begin
      pend_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ovf_q <= 1'b0;
    else if (clr_i)             ovf_q <= 1'b0;
    else if (viol && pend_q)    ovf_q <= 1'b1;
  end

  assign pend_o  = pend_q;
  assign cause_o = cause_q;
  assign vid_o   = vid_q;
  assign port_o  = port_q;
  assign ovf_o   = ovf_q;

  assert_record_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> $stable(vid_q) && $stable(port_q) && $stable(cause_q));
  assert_drop_sets_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i && viol |=> ovf_q);
  assert_pend_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q);
  assert_clear_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !viol |=> !pend_q && !ovf_q);
  assert_collide_no_ovf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && viol |=> pend_q && !ovf_q);
endmodule

// File: rtl/vvc_readout.sv
module vvc_readout
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              pend_i,
  input  cause_e            cause_i,
  input  logic [VID_W-1:0]  vid_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic              ovf_i,
  output logic [RD_W-1:0]   word_o,
  output logic [VID_W-1:0]  vid_o
);
  logic [RD_W-1:0]  word_d, word_q;
  logic [VID_W-1:0] vid_q;

  always_comb begin
    word_d = '0;
    if (pend_i) begin
      word_d[PORT_W-1:0] = port_i;
      word_d[MISS_BIT]   = (cause_i == CAUSE_MISS);
      word_d[MEMB_BIT]   = (cause_i == CAUSE_MEMBER);
      word_d[OVF_BIT]    = ovf_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      vid_q  <= '0;
    end else if (clr_i) begin
      word_q <= word_d;
      vid_q  <= pend_i ? vid_i : '0;
    end
  end

  assign word_o = word_q;
  assign vid_o  = vid_q;

  assert_empty_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !pend_i |=> word_q == '0 && vid_q == '0);
  assert_rsvd_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_q[RD_W-1:OVF_BIT+1] == '0 && !word_q[4]);
  assert_cause_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({word_q[MISS_BIT], word_q[MEMB_BIT]}));
  assert_rd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(word_q) && $stable(vid_q));
endmodule

// File: rtl/vlan_viol_capture.sv
module vlan_viol_capture
  import vvc_pkg::*;
#(
  parameter int unsigned PORT_W = 4,
  parameter int unsigned VID_W  = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [PORT_W-1:0] lkp_port_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  input  logic              lkp_hit_i,
  input  logic              lkp_member_i,
  input  logic              clr_i,
  output logic [15:0]       rd_word_o,
  output logic [VID_W-1:0]  rd_vid_o,
  output logic              irq_o
);
  cause_e            cls_cause, rec_cause;
  logic              rec_pend, rec_ovf;
  logic [VID_W-1:0]  rec_vid;
  logic [PORT_W-1:0] rec_port;

  initial begin
    assert_port_fits_R11: assert (PORT_W >= 1 && PORT_W <= PORT_MAX);
  end

  vvc_classify u_cls (
    .valid_i  (lkp_valid_i),
    .hit_i    (lkp_hit_i),
    .member_i (lkp_member_i),
    .cause_o  (cls_cause)
  );

  vvc_capture #(.PORT_W(PORT_W), .VID_W(VID_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cause_i (cls_cause),
    .vid_i   (lkp_vid_i),
    .port_i  (lkp_port_i),
    .clr_i   (clr_i),
    .pend_o  (rec_pend),
    .cause_o (rec_cause),
    .vid_o   (rec_vid),
    .port_o  (rec_port),
    .ovf_o   (rec_ovf)
  );

  vvc_readout #(.PORT_W(PORT_W), .VID_W(VID_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .pend_i  (rec_pend),
    .cause_i (rec_cause),
    .vid_i   (rec_vid),
    .port_i  (rec_port),
    .ovf_i   (rec_ovf),
    .word_o  (rd_word_o),
    .vid_o   (rd_vid_o)
  );

  assign irq_o = rec_pend;

  assert_irq_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i && !lkp_hit_i |=> irq_o);
  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !(lkp_valid_i && !(lkp_hit_i && lkp_member_i)) |=> !irq_o);
  assert_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(lkp_valid_i && !(lkp_hit_i && lkp_member_i)) |=> !irq_o);
endmodule

// File: tb/vlan_viol_capture_tb.sv
module vlan_viol_capture_tb_top;
  localparam int PORT_W = 4;
  localparam int VID_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0, hit = 1'b0, member = 1'b0, clr = 1'b0;
  logic [PORT_W-1:0] port = '0;
  logic [VID_W-1:0]  vid = '0;
  logic [15:0]       rd_word;
  logic [VID_W-1:0]  rd_vid;
  logic              irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vlan_viol_capture #(.PORT_W(PORT_W), .VID_W(VID_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lkp_valid_i(valid), .lkp_port_i(port),
    .lkp_vid_i(vid), .lkp_hit_i(hit), .lkp_member_i(member), .clr_i(clr),
    .rd_word_o(rd_word), .rd_vid_o(rd_vid), .irq_o(irq));

  function automatic logic [15:0] exp_word(logic [3:0] p, logic mi, logic me, logic ov);
    return (16'(ov) << 7) | (16'(me) << 6) | (16'(mi) << 5) | 16'(p);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one-cycle stimulus, sampled at the next falling edge
  task automatic step(logic v, logic h, logic m, logic [3:0] p, logic [11:0] id, logic c);
    valid = v; hit = h; member = m; port = p; vid = id; clr = c;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 word", 32'(rd_word), 0);
    chk("R1 vid", 32'(rd_vid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every port, every (valid,hit,member) combination
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic v, h, m, mi, me, any;
        logic [11:0] id;
        v = k[2]; h = k[1]; m = k[0];
        id = 12'((p * 257 + k * 73 + 5) % 4096);
        mi = v && !h;
        me = v && h && !m;
        any = mi || me;
        step(v, h, m, 4'(p), id, 1'b0);
        chk(any ? "R5 irq set" : "R4 irq quiet", 32'(irq), 32'(any));
        step(1'b0, 1'b0, 1'b0, 4'd0, 12'd0, 1'b1);
        chk(mi ? "R2 word" : (me ? "R3 word" : "R9 word"), 32'(rd_word),
            32'(any ? exp_word(4'(p), mi, me, 1'b0) : 16'h0));
        chk(any ? "R2 vid" : "R9 vid", 32'(rd_vid), any ? 32'(id) : 0);
        chk("R6 irq low", 32'(irq), 0);
        chk("R11 rsvd", 32'(rd_word & 16'hFF10), 0);
      end
    end

    // R7/R8: stacked violations
    step(1'b1, 1'b0, 1'b1, 4'd9, 12'hABC, 1'b0);
    step(1'b1, 1'b1, 1'b0, 4'd3, 12'h123, 1'b0);
    step(1'b1, 1'b0, 1'b0, 4'd4, 12'h456, 1'b0);
    chk("R5 irq held", 32'(irq), 1);
    step(1'b0, 1'b0, 1'b0, 4'd0, 12'd0, 1'b1);
    chk("R7 first kept word", 32'(rd_word), 32'(exp_word(4'd9, 1'b1, 1'b0, 1'b1)));
    chk("R7 first kept vid", 32'(rd_vid), 32'h0ABC);
    chk("R8 ovf bit", 32'(rd_word[7]), 1);
    step(1'b0, 1'b0, 1'b0, 4'd0, 12'd0, 1'b1);
    chk("R8 ovf cleared", 32'(rd_word), 0);
    chk("R9 empty vid", 32'(rd_vid), 0);

    // R10: violation colliding with get-and-clear
    step(1'b1, 1'b1, 1'b0, 4'd14, 12'hFFF, 1'b0);
    step(1'b1, 1'b0, 1'b1, 4'd2, 12'h001, 1'b1);
    chk("R10 old out", 32'(rd_word), 32'(exp_word(4'd14, 1'b0, 1'b1, 1'b0)));
    chk("R10 old vid", 32'(rd_vid), 32'h0FFF);
    chk("R10 irq stays", 32'(irq), 1);
    step(1'b0, 1'b0, 1'b0, 4'd0, 12'd0, 1'b1);
    chk("R10 new in", 32'(rd_word), 32'(exp_word(4'd2, 1'b1, 1'b0, 1'b0)));
    chk("R10 new vid", 32'(rd_vid), 32'h001);
    chk("R6 irq low", 32'(irq), 0);

    // R6: readback stays put without a clear
    step(1'b1, 1'b0, 1'b0, 4'd7, 12'h777, 1'b0);
    chk("R6 rd hold", 32'(rd_word), 32'(exp_word(4'd2, 1'b1, 1'b0, 1'b0)));
    step(1'b0, 1'b0, 1'b0, 4'd0, 12'd0, 1'b1);
    chk("R2 last", 32'(rd_word), 32'(exp_word(4'd7, 1'b1, 1'b0, 1'b0)));
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule